// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is an SMBus target that owns a small bank of byte-wide configuration registers and serves them through indexed block transfers. The host writes by sending the target's write address, a starting index, a byte count and then that many data bytes, which land in consecutive registers. To read, the host first sets the starting index in a write-addressed phase. It then issues a repeated START with the read address. The target answers with a byte count, taken from the last register of the bank, followed by register contents from the starting index upward.

The bus pins arrive as raw SCL and SDA levels that the block oversamples with its own clock. SDA is driven through an open-drain enable: when `sda_oe` is high the pad pulls the line low, otherwise the line floats high. The whole register bank is presented on a flat parallel output, so the chip's logic can use the settings without a handshake. Because the register bank is plain control state, the block has no stream interface. The bus side has no back-pressure: the block never stretches SCL, so every byte it accepts is stored in the cycle its eighth bit is sampled.

Top module: `smb_idx_regs`

## Requirements
- R1: During and right after reset, registers 0 to 7 hold A0h plus their index (A0h, A1h, ... A7h), register 8 holds 08h, and `sda_oe` is low.
- R2: An address byte of D4h (write) or D5h (read) is ACKed. Any other address byte is NACKed, and every following byte is NACKed and ignored until the next START.
- R3: In a write transfer the index byte and the count byte are ACKed. Each following data byte is ACKed and stored at the index, then the index advances by one.
- R4: Once the count has been used up, any further data byte is NACKed and not stored. A count of zero makes the first data byte NACKed.
- R5: A data byte aimed at an index above 8 is ACKed but changes no register.
- R6: After the read address is ACKed, the target sends register 8 as the count byte. It then sends the registers from the last written index upward, one per byte, for as long as the host ACKs.
- R7: A read of an index above 8 returns 00h.
- R8: After the host NACKs a byte, the target leaves SDA released (the host reads FFh) until a START or STOP.
- R9: A START or STOP recognised at any time, including in the middle of a byte, restarts the protocol. A transfer that follows behaves normally.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| regs_flat | output | NREGS*8 | Register bank, register i at bits [8i+7:8i] |

## Verification
A corrupted byte role or index shows up on the bus within one byte time. It appears as a wrong ACK/NACK on the next byte, or as a wrong value in the count or data bytes the host reads back. A wrong write index shows on `regs_flat` one clock after the eighth SCL rise of the data byte. A stuck transmit state shows as SDA held low after a host NACK or a STOP, and a bit mistimed against SCL shows as `sda_oe` moving while SCL is high. Both are visible in the very next bit period.

// File: rtl/smb_idx_pkg.sv
package smb_idx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK,
    PH_HOLD
  } phase_t;

  typedef enum logic [1:0] {
    RB_ADDR,
    RB_INDEX,
    RB_COUNT,
    RB_DATA
  } rx_role_t;

  // Reset contents: the count register holds its own index, the rest A0h+index.
  function automatic logic [7:0] reg_reset_val(input int idx, input int cnt_idx);
    if (idx == cnt_idx) return 8'(cnt_idx);
    return 8'hA0 + 8'(idx);
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_idx_bank.sv
module smb_idx_bank
  import smb_idx_pkg::*;
#(
  parameter int NREGS = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [7:0]         rd_idx,
  output logic [7:0]         rd_data,
  output logic [7:0]         cnt_val,
  output logic [NREGS*8-1:0] regs_flat
);

  localparam int CNT_IDX = NREGS - 1;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= reg_reset_val(g, CNT_IDX);
      else if (wr_en && wr_idx == 8'(g))   q <= wr_data;
    end
    assign regs_flat[g*8 +: 8] = q;
  end

  // Indices past the bank read as zero.
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (rd_idx == 8'(i)) rd_data = regs_flat[i*8 +: 8];
    end
  end

  assign cnt_val = regs_flat[CNT_IDX*8 +: 8];

endmodule

// File: rtl/smb_idx_fsm.sv
module smb_idx_fsm
  import smb_idx_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h6A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  input  logic [7:0] cnt_val,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic [7:0] rd_idx,
  output logic       sda_oe
);

  localparam logic [7:0] ADDR_WR = {ADDR7, 1'b0};
  localparam logic [7:0] ADDR_RD = {ADDR7, 1'b1};

  phase_t     ph;
  rx_role_t   role;
  logic [2:0] bitcnt;
  logic [6:0] rxsh;
  logic [7:0] txsh, ptr, remain;
  logic       byte_done, byte_ok, go_tx, host_ack;
  logic [7:0] rx_byte;
  logic       last_bit, accept;

  assign rx_byte  = {rxsh, sda_s};
  assign last_bit = (bitcnt == 3'd7);

  always_comb begin
    unique case (role)
      RB_ADDR:  accept = (rx_byte == ADDR_WR) || (rx_byte == ADDR_RD);
      RB_DATA:  accept = (remain != 8'd0);
      default:  accept = 1'b1;
    endcase
  end

  assign wr_en   = (ph == PH_RX) && scl_rise && !byte_done && last_bit &&
                   (role == RB_DATA) && (remain != 8'd0);
  assign wr_idx  = ptr;
  assign wr_data = rx_byte;
  assign rd_idx  = ptr;
  assign sda_oe  = (ph == PH_RX_ACK) || ((ph == PH_TX) && !txsh[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      role      <= RB_ADDR;
      bitcnt    <= '0;
      rxsh      <= '0;
      txsh      <= '1;
      ptr       <= '0;
      remain    <= '0;
      byte_done <= 1'b0;
      byte_ok   <= 1'b0;
      go_tx     <= 1'b0;
      host_ack  <= 1'b0;
    end else if (start_det) begin
      ph        <= PH_RX;
      role      <= RB_ADDR;
      bitcnt    <= '0;
      byte_done <= 1'b0;
      go_tx     <= 1'b0;
    end else if (stop_det) begin
      ph        <= PH_IDLE;
      byte_done <= 1'b0;
      go_tx     <= 1'b0;
    end else begin
      unique case (ph)
        PH_RX: begin
          if (scl_rise && !byte_done) begin
            rxsh   <= rx_byte[6:0];
            bitcnt <= bitcnt + 3'd1;
            if (last_bit) begin
              byte_done <= 1'b1;
              byte_ok   <= accept;
              unique case (role)
                RB_ADDR: begin
                  if (rx_byte == ADDR_RD) begin
                    go_tx <= 1'b1;
                    txsh  <= cnt_val;
                  end else begin
                    role <= RB_INDEX;
                  end
                end
                RB_INDEX: begin
                  ptr  <= rx_byte;
                  role <= RB_COUNT;
                end
                RB_COUNT: begin
                  remain <= rx_byte;
                  role   <= RB_DATA;
                end
                RB_DATA: begin
                  if (remain != 8'd0) begin
                    ptr    <= ptr + 8'd1;
                    remain <= remain - 8'd1;
                  end
                end
              endcase
            end
          end else if (scl_fall && byte_done) begin
            byte_done <= 1'b0;
            ph        <= byte_ok ? PH_RX_ACK : PH_HOLD;
          end
        end
        PH_RX_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            ph     <= go_tx ? PH_TX : PH_RX;
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            txsh   <= {txsh[6:0], 1'b1};
            bitcnt <= bitcnt + 3'd1;
            if (last_bit) begin
              ph       <= PH_TX_ACK;
              host_ack <= 1'b0;
            end
          end
        end
        PH_TX_ACK: begin
          if (scl_rise) begin
            host_ack <= !sda_s;
            if (!sda_s) begin
              txsh <= rd_data;
              ptr  <= ptr + 8'd1;
            end
          end else if (scl_fall) begin
            bitcnt <= '0;
            ph     <= host_ack ? PH_TX : PH_HOLD;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/smb_idx_regs.sv
module smb_idx_regs #(
  parameter logic [6:0] ADDR7       = 7'h6A,
  parameter int         NREGS       = 9,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  output logic [NREGS*8-1:0] regs_flat
);

  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_en;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data, cnt_val;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_idx_fsm #(.ADDR7(ADDR7)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .cnt_val   (cnt_val),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx),
    .sda_oe    (sda_oe)
  );

  smb_idx_bank #(.NREGS(NREGS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .cnt_val   (cnt_val),
    .regs_flat (regs_flat)
  );

endmodule

// File: rtl/smb_idx_regs_chk.sv
module smb_idx_regs_chk #(
  parameter int NREGS = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_in,
  input logic               sda_oe,
  input logic [NREGS*8-1:0] regs_flat,
  input logic               wr_en,
  input logic [7:0]         wr_idx,
  input logic               stop_det
);

  AST_RESET_RELEASED: assert property (@(posedge clk)
    !rst_n |=> !sda_oe); // R1

  AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat)); // R3

  AST_OOR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= 8'(NREGS)) |=> $stable(regs_flat)); // R5

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R9

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_in); // R10

endmodule

bind smb_idx_regs smb_idx_regs_chk #(.NREGS(NREGS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_in    (scl_in),
  .sda_oe    (sda_oe),
  .regs_flat (regs_flat),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .stop_det  (stop_det)
);

// File: tb/smb_idx_regs_test.sv
module smb_idx_regs_test;

  localparam int CLK_PERIOD = 10;
  localparam int NREGS      = 9;
  localparam int Q          = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [NREGS*8-1:0] regs_flat;

  assign sda_bus = host_sda & ~sda_oe;

  smb_idx_regs uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (host_scl),
    .sda_in    (sda_bus),
    .sda_oe    (sda_oe),
    .regs_flat (regs_flat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [7:0] model [NREGS];
  string      req_q[$];
  logic [7:0] val_q[$];
  logic [7:0] obs_val;
  event       obs_ev;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic qwait();
    repeat (Q) @(posedge clk);
    #2;
  endtask

  task automatic bus_start();
    host_sda = 1'b1; qwait();
    host_scl = 1'b1; qwait();
    host_sda = 1'b0; qwait();
    host_scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; qwait();
    host_scl = 1'b1; qwait();
    host_sda = 1'b1; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; qwait();
      host_scl = 1'b1; qwait(); qwait();
      host_scl = 1'b0; qwait();
    end
    host_sda = 1'b1; qwait();
    host_scl = 1'b1; qwait();
    acked = !sda_bus;
    qwait();
    host_scl = 1'b0; qwait();
  endtask

  task automatic put(input string req, input logic [7:0] b, input logic exp_ack);
    logic a;
    send_byte(b, a);
    chk(req, {7'd0, a}, {7'd0, exp_ack});
  endtask

  task automatic recv_byte(input logic give_ack);
    logic [7:0] b;
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qwait();
      host_scl = 1'b1; qwait();
      b[i] = sda_bus;
      qwait();
      host_scl = 1'b0;
    end
    qwait();
    host_sda = give_ack ? 1'b0 : 1'b1; qwait();
    host_scl = 1'b1; qwait(); qwait();
    host_scl = 1'b0; qwait();
    host_sda = 1'b1;
    obs_val = b;
    -> obs_ev;
  endtask

  task automatic expect_item(input string req, input logic [7:0] v);
    req_q.push_back(req);
    val_q.push_back(v);
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < NREGS; i++) chk(req, regs_flat[i*8 +: 8], model[i]);
  endtask

  // Monitor: pops the expected stream and compares each byte read off the bus.
  initial begin
    forever begin
      @(obs_ev);
      if (req_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R6: got %h expected nothing queued", obs_val);
      end else begin
        string r;
        logic [7:0] v;
        r = req_q.pop_front();
        v = val_q.pop_front();
        chk(r, obs_val, v);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NREGS; i++) model[i] = (i == NREGS-1) ? 8'(NREGS-1) : 8'hA0 + 8'(i);
    repeat (4) @(posedge clk);
    #2;
    chk("R1", {7'd0, sda_oe}, 8'd0);
    rst_n = 1'b1;
    qwait();
    chk_regs("R1");
    chk("R1", {7'd0, sda_oe}, 8'd0);

    // R3: block write of three bytes at index 2
    bus_start();
    put("R2", 8'hD4, 1'b1);
    put("R3", 8'h02, 1'b1);
    put("R3", 8'h03, 1'b1);
    put("R3", 8'h11, 1'b1);
    put("R3", 8'h22, 1'b1);
    put("R3", 8'h33, 1'b1);
    bus_stop();
    model[2] = 8'h11; model[3] = 8'h22; model[4] = 8'h33;
    chk_regs("R3");

    // R4: byte past the count is refused
    bus_start();
    put("R2", 8'hD4, 1'b1);
    put("R4", 8'h00, 1'b1);
    put("R4", 8'h01, 1'b1);
    put("R4", 8'h55, 1'b1);
    put("R4", 8'h66, 1'b0);
    bus_stop();
    model[0] = 8'h55;
    chk_regs("R4");

    // R4: zero count refuses the first data byte
    bus_start();
    put("R2", 8'hD4, 1'b1);
    put("R4", 8'h01, 1'b1);
    put("R4", 8'h00, 1'b1);
    put("R4", 8'h99, 1'b0);
    bus_stop();
    chk_regs("R4");

    // R2: foreign address NACKed, rest ignored
    bus_start();
    put("R2", 8'hA0, 1'b0);
    put("R2", 8'h01, 1'b0);
    put("R2", 8'h01, 1'b0);
    bus_stop();
    chk_regs("R2");

    // R5: count register set to 3, next byte lands past the bank
    bus_start();
    put("R2", 8'hD4, 1'b1);
    put("R5", 8'h08, 1'b1);
    put("R5", 8'h02, 1'b1);
    put("R5", 8'h03, 1'b1);
    put("R5", 8'h77, 1'b1);
    bus_stop();
    model[8] = 8'h03;
    chk_regs("R5");

    // R6: indexed block read from index 2
    bus_start();
    put("R2", 8'hD4, 1'b1);
    put("R6", 8'h02, 1'b1);
    bus_start();
    put("R2", 8'hD5, 1'b1);
    expect_item("R6", model[8]);
    expect_item("R6", model[2]);
    expect_item("R6", model[3]);
    expect_item("R6", model[4]);
    recv_byte(1'b1);
    recv_byte(1'b1);
    recv_byte(1'b1);
    recv_byte(1'b0);
    bus_stop();

    // R7: read running past the bank end
    bus_start();
    put("R2", 8'hD4, 1'b1);
    put("R7", 8'h07, 1'b1);
    bus_start();
    put("R2", 8'hD5, 1'b1);
    expect_item("R7", model[8]);
    expect_item("R7", model[7]);
    expect_item("R7", model[8]);
    expect_item("R7", 8'h00);
    recv_byte(1'b1);
    recv_byte(1'b1);
    recv_byte(1'b1);
    recv_byte(1'b0);
    bus_stop();

    // R8: after a host NACK the line stays released
    bus_start();
    put("R2", 8'hD4, 1'b1);
    put("R8", 8'h00, 1'b1);
    bus_start();
    put("R2", 8'hD5, 1'b1);
    expect_item("R8", model[8]);
    expect_item("R8", model[0]);
    expect_item("R8", 8'hFF);
    recv_byte(1'b1);
    recv_byte(1'b0);
    recv_byte(1'b0);
    bus_stop();

    // R9: START in the middle of a byte, then a normal write
    bus_start();
    for (int i = 0; i < 4; i++) begin
      host_sda = 1'b1; qwait();
      host_scl = 1'b1; qwait(); qwait();
      host_scl = 1'b0; qwait();
    end
    bus_start();
    put("R9", 8'hD4, 1'b1);
    put("R9", 8'h01, 1'b1);
    put("R9", 8'h01, 1'b1);
    put("R9", 8'h5A, 1'b1);
    bus_stop();
    model[1] = 8'h5A;
    chk_regs("R9");
    chk("R9", {7'd0, sda_oe}, 8'd0);

    repeat (4) @(posedge clk);
    #2;
    chk("R6", 8'(req_q.size()), 8'd0);
    finish_run();
  end

endmodule